// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the bit-rate timing for a serial transmitter and receiver from the system clock. The clock passes through two dividers in series. The first is a prescaler with a factor of 1, 3, 4 or 13. The second divides the prescaler output by a power of two from 1 to 128. The result is a one-cycle oversampling tick for the receiver. A further divide by 16 gives the transmit bit tick. Both directions share this one rate.

An 8-bit control register sets the rate, and the same value can be read back. Any write to the register restarts every counter in the chain, so the new rate begins from a known phase. For production test, a clear bit holds the whole chain at zero. This bit can be set only while the test-mode input is high. The same bit is also how software leaves the held state.

Top module: `baud_gen`

## Requirements
- R1: Control bits 5:4 select the prescale factor P. The codes are 00 for 1, 01 for 3, 10 for 4 and 11 for 13.
- R2: Control bits 2:0 hold a value S, and the second stage divides by 2^S. Apart from a restart, `rx_tick_o` pulses once every N = P*2^S clocks.
- R3: `tx_tick_o` pulses on every 16th `rx_tick_o` pulse, in the same cycle as that pulse, and never on its own.
- R4: `tx_tick_o` is always one clock wide. When N > 1, each `rx_tick_o` pulse is one clock wide. When N = 1, `rx_tick_o` is high in every cycle.
- R5: A write restarts the chain. Cycle k is the k-th cycle after the write's clock edge, counting from 0. The first `rx_tick_o` comes in cycle N-1 and the second in cycle 2N-1. The first `tx_tick_o` comes in cycle 16N-1.
- R6: The read value is {0, 0, prescale select, receive-test bit, rate select}. Bits 7 and 6 always read 0. Bit 3 is stored and read back but has no effect on timing.
- R7: After reset, read bits 7:3 are 0. The rate select bits are not reset.
- R8: Writing bit 7 = 1 while `test_mode_i` is high sets the clear bit. While it is set, both ticks stay low. The chain leaves this state through a write with bit 7 = 0, or when `test_mode_i` falls. Timing then restarts as in R5, counted from the edge at which the clear bit drops.
- R9: Writing bit 7 = 1 while `test_mode_i` is low does not stop the ticks. The rest of the written value takes effect as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Allows the chain-clear bit to be set |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write value |
| rd_data_o | output | 8 | Control register read value |
| rx_tick_o | output | 1 | Receiver oversampling tick |
| tx_tick_o | output | 1 | Transmit bit-rate tick |

## Verification
A wrong prescaler or second-stage count changes the tick period, which shows at the ports within one period of at most 1664 clocks. Wrong restart logic moves the first tick after a write away from cycle N-1. A fault in the 16-count is seen only at the first transmit tick, which comes 16N-1 cycles after a write. A stuck clear bit silences both ticks at once. A clear bit that fails to take effect, or that is not gated by test mode, shows as a tick that appears or stays missing within N cycles.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int PSEL_W = 2;
  localparam int RSEL_W = 3;
  localparam int PCNT_W = 4;
  localparam int OVS    = 16;

  typedef struct packed {
    logic              tclr;
    logic [PSEL_W-1:0] psel;
    logic              rxtest;
    logic [RSEL_W-1:0] rsel;
  } baud_cfg_t;

  function automatic logic [PCNT_W-1:0] pre_factor(input logic [PSEL_W-1:0] sel);
    case (sel)
      2'd0:    pre_factor = PCNT_W'(1);
      2'd1:    pre_factor = PCNT_W'(3);
      2'd2:    pre_factor = PCNT_W'(4);
      default: pre_factor = PCNT_W'(13);
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_gen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      test_mode_i,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  output baud_cfg_t cfg_o,
  output logic [7:0] rd_data_o
);
  logic              tclr_q;
  logic [PSEL_W-1:0] psel_q;
  logic              rxtest_q;
  logic [RSEL_W-1:0] rsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tclr_q   <= 1'b0;
      psel_q   <= '0;
      rxtest_q <= 1'b0;
    end else begin
      if (!test_mode_i)  tclr_q <= 1'b0;
      else if (wr_en_i)  tclr_q <= wr_data_i[7];
      if (wr_en_i) begin
        psel_q   <= wr_data_i[5:4];
        rxtest_q <= wr_data_i[3];
      end
    end
  end

  // rate select has no reset value
  always_ff @(posedge clk_i) begin
    if (wr_en_i) rsel_q <= wr_data_i[RSEL_W-1:0];
  end

  assign cfg_o     = '{tclr: tclr_q, psel: psel_q, rxtest: rxtest_q, rsel: rsel_q};
  assign rd_data_o = {2'b00, psel_q, rxtest_q, rsel_q};
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              p_tick_o
);
  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] factor;

  assign factor   = pre_factor(psel_i);
  assign p_tick_o = (pcnt_q == factor - PCNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (p_tick_o)  pcnt_q <= '0;
    else                pcnt_q <= pcnt_q + PCNT_W'(1);
  end

  assert_pcnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q < factor);
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div
  import baud_gen_pkg::*;
#(
  parameter int SEL_W  = RSEL_W,
  parameter int OVS_N  = OVS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic             p_tick_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic             rx_tick_o,
  output logic             tx_tick_o
);
  localparam int DCNT_W = (2 ** SEL_W) - 1;
  localparam int OCNT_W = $clog2(OVS_N);

  logic [DCNT_W-1:0] dcnt_q, last;
  logic [DCNT_W:0]   span;
  logic [OCNT_W-1:0] ocnt_q;

  assign span      = (DCNT_W+1)'(1) << rsel_i;
  assign last      = DCNT_W'(span - (DCNT_W+1)'(1));
  assign rx_tick_o = !hold_i && p_tick_i && (dcnt_q == last);
  assign tx_tick_o = rx_tick_o && (ocnt_q == OCNT_W'(OVS_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dcnt_q <= '0;
    else if (restart_i) dcnt_q <= '0;
    else if (p_tick_i)  dcnt_q <= (dcnt_q == last) ? '0 : dcnt_q + DCNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ocnt_q <= '0;
    else if (restart_i) ocnt_q <= '0;
    else if (rx_tick_o) ocnt_q <= (ocnt_q == OCNT_W'(OVS_N - 1)) ? '0 : ocnt_q + OCNT_W'(1);
  end

  assert_rx_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_tick_o && !restart_i && last != '0) |=> !rx_tick_o);
  assert_tx_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |=> !tx_tick_o);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       test_mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       rx_tick_o,
  output logic       tx_tick_o
);
  baud_cfg_t cfg;
  logic      restart, p_tick;

  assign restart = wr_en_i || cfg.tclr;

  baud_cfg_reg u_cfg (
    .clk_i, .rst_ni, .test_mode_i, .wr_en_i, .wr_data_i,
    .cfg_o(cfg), .rd_data_o
  );

  baud_prescaler u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .psel_i(cfg.psel), .p_tick_o(p_tick)
  );

  baud_rate_div #(.SEL_W(RSEL_W), .OVS_N(OVS)) u_div (
    .clk_i, .rst_ni, .restart_i(restart), .hold_i(cfg.tclr),
    .p_tick_i(p_tick), .rsel_i(cfg.rsel), .rx_tick_o, .tx_tick_o
  );

  assert_tx_on_rx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> rx_tick_o);
  assert_clear_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.tclr |-> (!rx_tick_o && !tx_tick_o));
  assert_no_tx_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tx_tick_o);
endmodule

// File: tb/baud_gen_tb_top.sv
module baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_tick, tx_tick;
  int         errors = 0;
  int         checks = 0;

  always #5ns clk = ~clk;

  baud_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .rx_tick_o(rx_tick), .tx_tick_o(tx_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // leaves caller at the negedge of cycle 0 after the write edge
  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int fac(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 3; 2'd2: return 4; default: return 13; endcase
  endfunction

  // samples from cycle 0 onward and checks phase/period/width (R1 R2 R3 R4 R5)
  task automatic measure(input string tag, input int n);
    int first_rx = -1, second_rx = -1, first_tx = -1, rx_cnt = 0, wide = 0;
    int prev_rx = 0;
    for (int k = 0; k < 16 * n + 2; k++) begin
      if (rx_tick) begin
        if (first_rx < 0) first_rx = k;
        else if (second_rx < 0) second_rx = k;
        if (first_tx < 0) rx_cnt++;
        if (prev_rx != 0 && n > 1) wide++;
      end
      if (tx_tick && first_tx < 0) first_tx = k;
      if (tx_tick && !rx_tick) wide++;
      prev_rx = int'(rx_tick);
      @(negedge clk);
    end
    chk({tag, " R5 first rx"}, first_rx, n - 1);
    chk({tag, " R2 period"}, second_rx, 2 * n - 1);
    chk({tag, " R5 first tx"}, first_tx, 16 * n - 1);
    chk({tag, " R3 rx per tx"}, rx_cnt, 16);
    chk({tag, " R4 width"}, wide, 0);
  endtask

  task automatic rate_case(input logic [1:0] ps, input logic [2:0] rs);
    int n = fac(ps) * (1 << rs);
    write_reg({2'b00, ps, 1'b0, rs});
    chk("R6 readback", int'(rd_data), int'({2'b00, ps, 1'b0, rs}));
    measure($sformatf("R1 P%0d S%0d", fac(ps), rs), n);
  endtask

  task automatic test_reset();
    chk("R7 reset upper bits", int'(rd_data[7:3]), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", int'(rd_data[7:3]), 0);
  endtask

  task automatic test_restart();
    write_reg(8'h21);  // P=4 S=1 N=8
    repeat (5) @(negedge clk);
    write_reg(8'h21);
    measure("R5 rewrite mid-count", 8);
  endtask

  task automatic test_rxtest_bit();
    write_reg(8'h1A);  // P=3 S=2 N=12, bit 3 set
    chk("R6 bit3 readback", int'(rd_data), 8'h1A);
    measure("R6 bit3 no effect", 12);
  endtask

  task automatic test_clear();
    int cnt = 0;
    test_mode = 1'b1;
    write_reg(8'h80);  // N=1 with clear
    chk("R6 bit7 reads 0", int'(rd_data[7:6]), 0);
    for (int k = 0; k < 40; k++) begin
      if (rx_tick || tx_tick) cnt++;
      @(negedge clk);
    end
    chk("R8 silent while clear", cnt, 0);
    write_reg(8'h00);
    measure("R8 release by write", 1);
    write_reg(8'h91);  // clear, P=3 S=1
    repeat (10) @(negedge clk);
    test_mode = 1'b0;
    @(negedge clk);
    measure("R8 release by test_mode", 6);
    write_reg(8'h91);  // test_mode low: bit7 ignored
    chk("R9 readback", int'(rd_data), 8'h11);
    measure("R9 clear ignored", 6);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    rate_case(2'd0, 3'd0);
    rate_case(2'd1, 3'd2);
    rate_case(2'd3, 3'd0);
    rate_case(2'd2, 3'd3);
    rate_case(2'd3, 3'd7);
    test_restart();
    test_rxtest_bit();
    test_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule